// File: doc/BRIEF.md
# Multi-Mode Program Bank Mapper

This block turns a small set of bank registers into the 8 KB program-ROM bank numbers seen by a CPU through four windows at 0x8000, 0xA000, 0xC000 and 0xE000. It also drives an optional fifth window at 0x6000, with a valid flag of its own. A two-bit size mode chooses how the registers are applied. The four choices are a fixed top 32 KB, a switchable 16 KB pair, individually switched 8 KB windows, or the registers applied in reverse order.

Software loads the four bank registers and one control word through a single indexed write port. The total number of 8 KB banks in the ROM comes in as a power-of-two input. Every bank number is wrapped into that range. All outputs pass through one output register, which loads on every clock.

Top module: `prg_bank_mapper`

## Requirements
- R1: While reset is asserted all window outputs and the low-window valid are 0. After reset the size mode is 0, both flags are clear and all four bank registers read as zero.
- R2: A write with index 0 to 3 loads that bank register. A write with index 4 loads the control word: bits [1:0] are the size mode, bit 2 is the last-window-switchable flag and bit 3 is the low-window flag.
- R3: In size mode 0, windows 0 to 3 show banks count-4, count-3, count-2 and count-1.
- R4: In size mode 1, windows 0 and 1 show register1×2 and register1×2+1, and windows 2 and 3 show count-2 and count-1.
- R5: In size mode 2 with the last-window-switchable flag set, windows 0 to 3 show registers 0, 1, 2 and 3.
- R6: In size mode 2 with the last-window-switchable flag clear, windows 0 to 2 show registers 0, 1 and 2, and window 3 shows count-1.
- R7: The 0x6000 window is valid and shows register 3 only in size mode 2 with the last-window-switchable flag clear and the low-window flag set. In every other case its valid is 0 and its bank is 0.
- R8: In size mode 3, windows 0 to 3 show registers 3, 2, 1 and 0.
- R9: Every bank number shown is reduced modulo the bank count, which is a power of two of at least 4, so no output ever exceeds count-1.
- R10: A write presented before clock edge n is visible on the outputs after edge n+1 and not before. A change of bank count before edge n is visible after edge n.
- R11: A write with an index from 5 upward changes no register, so every output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | IDX_W | Write index: 0-3 bank registers, 4 control word |
| wr_data_i | input | BANK_W | Write data |
| bank_count_i | input | BANK_W+1 | Number of 8 KB banks in the ROM, a power of two |
| win_bank_o | output | 4×BANK_W | Bank numbers for windows 0x8000, 0xA000, 0xC000, 0xE000 (index 0 first) |
| low_bank_o | output | BANK_W | Bank number for the 0x6000 window |
| low_valid_o | output | 1 | 0x6000 window is mapped |

## Verification
The bench uses the default build: 8-bit bank registers, a 3-bit write index and the 0x6000 window enabled. With an 8-bit register and a 9-bit count input, bank counts from 4 to 256 can be swept. That sweep lets the wrap-around go from two significant bits up to none, both for fixed banks near the top and for large register values. The 3-bit index brings the three unused indices within reach, so the test can show that writes to them are ignored.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
   localparam int NUM_WIN  = 4;
   localparam int CTRL_IDX = 4;
   localparam int CTRL_W   = 4;

   typedef enum logic [1:0] {
      SZ_FIX32 = 2'd0,
      SZ_SW16  = 2'd1,
      SZ_SW8   = 2'd2,
      SZ_REV   = 2'd3
   } size_mode_e;

   typedef struct packed {
      logic       low_en;
      logic       last_sw;
      size_mode_e mode;
   } ctrl_t;
endpackage

// File: rtl/prg_regfile.sv
module prg_regfile
   import prg_map_pkg::*;
#(
   parameter int BANK_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [BANK_W-1:0]              wr_data,
   output logic [NUM_WIN-1:0][BANK_W-1:0] regs_o,
   output ctrl_t                          ctrl_o
);
   generate
      if (BANK_W < CTRL_W) begin : g_bad_w
         $error("prg_regfile: BANK_W must hold the control word");
      end
      if ((1 << IDX_W) <= CTRL_IDX) begin : g_bad_idx
         $error("prg_regfile: IDX_W too small to reach the control word");
      end
   endgenerate

   genvar g;
   generate
      for (g = 0; g < NUM_WIN; g++) begin : g_bank
         logic [BANK_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  q <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))       q <= wr_data;
         end
         assign regs_o[g] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ctrl_o <= '0;
      else if (wr_en && wr_idx == IDX_W'(CTRL_IDX)) ctrl_o <= ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   // R11: indices above the control word touch nothing
   a_r11_unused_idx: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx > IDX_W'(CTRL_IDX)) |=> ($stable(regs_o) && $stable(ctrl_o)));

   // R2: control word lands with its field layout
   a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(CTRL_IDX)) |=> (ctrl_o == ctrl_t'($past(wr_data[CTRL_W-1:0]))));
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
   import prg_map_pkg::*;
#(
   parameter int BANK_W = 8,
   parameter bit LOW_EN = 1'b1
) (
   input  logic [NUM_WIN-1:0][BANK_W-1:0] regs_i,
   input  ctrl_t                          ctrl_i,
   input  logic [BANK_W-1:0]              mask_i,
   output logic [NUM_WIN-1:0][BANK_W-1:0] win_o,
   output logic [BANK_W-1:0]              low_bank_o,
   output logic                           low_valid_o
);
   logic [NUM_WIN-1:0][BANK_W-1:0] raw;
   logic [BANK_W-1:0]              pair_base;

   assign pair_base = {regs_i[1][BANK_W-2:0], 1'b0};

   always_comb begin
      raw = '0;
      unique case (ctrl_i.mode)
         SZ_FIX32: begin
            for (int i = 0; i < NUM_WIN; i++) raw[i] = mask_i - BANK_W'(NUM_WIN - 1 - i);
         end
         SZ_SW16: begin
            raw[0] = pair_base;
            raw[1] = pair_base | BANK_W'(1);
            raw[2] = mask_i - BANK_W'(1);
            raw[3] = mask_i;
         end
         SZ_SW8: begin
            for (int i = 0; i < NUM_WIN - 1; i++) raw[i] = regs_i[i];
            raw[NUM_WIN-1] = ctrl_i.last_sw ? regs_i[NUM_WIN-1] : mask_i;
         end
         SZ_REV: begin
            for (int i = 0; i < NUM_WIN; i++) raw[i] = regs_i[NUM_WIN-1-i];
         end
         default: raw = '0;
      endcase
   end

   genvar g;
   generate
      for (g = 0; g < NUM_WIN; g++) begin : g_wrap
         assign win_o[g] = raw[g] & mask_i;
      end

      if (LOW_EN) begin : g_low
         logic hit;
         assign hit         = (ctrl_i.mode == SZ_SW8) && !ctrl_i.last_sw && ctrl_i.low_en;
         assign low_valid_o = hit;
         assign low_bank_o  = hit ? (regs_i[NUM_WIN-1] & mask_i) : '0;
      end else begin : g_no_low
         assign low_valid_o = 1'b0;
         assign low_bank_o  = '0;
      end
   endgenerate
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
   import prg_map_pkg::*;
#(
   parameter int BANK_W = 8,
   parameter int IDX_W  = 3,
   parameter bit LOW_EN = 1'b1,
   localparam int CNT_W = BANK_W + 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en_i,
   input  logic [IDX_W-1:0]               wr_idx_i,
   input  logic [BANK_W-1:0]              wr_data_i,
   input  logic [CNT_W-1:0]               bank_count_i,
   output logic [NUM_WIN-1:0][BANK_W-1:0] win_bank_o,
   output logic [BANK_W-1:0]              low_bank_o,
   output logic                           low_valid_o
);
   logic [NUM_WIN-1:0][BANK_W-1:0] regs;
   ctrl_t                          ctrl;
   logic [BANK_W-1:0]              mask;
   logic [NUM_WIN-1:0][BANK_W-1:0] win_d;
   logic [BANK_W-1:0]              low_bank_d;
   logic                           low_valid_d;

   assign mask = BANK_W'(bank_count_i - CNT_W'(1));

   prg_regfile #(.BANK_W(BANK_W), .IDX_W(IDX_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_i),
      .wr_idx  (wr_idx_i),
      .wr_data (wr_data_i),
      .regs_o  (regs),
      .ctrl_o  (ctrl)
   );

   prg_window_map #(.BANK_W(BANK_W), .LOW_EN(LOW_EN)) u_map (
      .regs_i      (regs),
      .ctrl_i      (ctrl),
      .mask_i      (mask),
      .win_o       (win_d),
      .low_bank_o  (low_bank_d),
      .low_valid_o (low_valid_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_bank_o  <= '0;
         low_bank_o  <= '0;
         low_valid_o <= 1'b0;
      end else begin
         win_bank_o  <= win_d;
         low_bank_o  <= low_bank_d;
         low_valid_o <= low_valid_d;
      end
   end

   // R3: fixed mode puts the top bank in the last window
   a_r3_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ctrl.mode == SZ_FIX32)) |-> (win_bank_o[NUM_WIN-1] == $past(mask)));

   // R4: 16 KB mode gives an even/odd pair in windows 0 and 1
   a_r4_pair: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ctrl.mode == SZ_SW16)) |->
      (!win_bank_o[0][0] && win_bank_o[1] == (win_bank_o[0] | BANK_W'(1))));

   // R8: reverse mode shows register 3 in window 0
   a_r8_reverse: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ctrl.mode == SZ_REV)) |->
      (win_bank_o[0] == ($past(regs[NUM_WIN-1]) & $past(mask))));

   // R7: low window valid only in its one configuration
   a_r7_low_valid: assert property (@(posedge clk) disable iff (!rst_n)
      low_valid_o |-> $past(ctrl.mode == SZ_SW8 && !ctrl.last_sw && ctrl.low_en));

   a_r7_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !low_valid_o |-> (low_bank_o == '0));

   // R9: no bank number beyond the ROM
   genvar g;
   generate
      for (g = 0; g < NUM_WIN; g++) begin : g_chk
         a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (win_bank_o[g] <= $past(mask)));
      end
   endgenerate
endmodule

// File: tb/prg_bank_mapper_tb.sv
module prg_bank_mapper_tb;
   localparam int BW = 8;
   localparam int IW = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [IW-1:0]     wr_idx = '0;
   logic [BW-1:0]     wr_data = '0;
   logic [BW:0]       bank_count = 9'd16;
   logic [3:0][BW-1:0] win;
   logic [BW-1:0]     low_bank;
   logic              low_valid;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [BW-1:0] bregs [4];
   logic [1:0]    bmode = 2'd0;
   logic          blast = 1'b0;
   logic          blow = 1'b0;
   int            bcount = 16;

   always #4 clk = ~clk;

   prg_bank_mapper #(.BANK_W(BW), .IDX_W(IW), .LOW_EN(1'b1)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en_i      (wr_en),
      .wr_idx_i     (wr_idx),
      .wr_data_i    (wr_data),
      .bank_count_i (bank_count),
      .win_bank_o   (win),
      .low_bank_o   (low_bank),
      .low_valid_o  (low_valid)
   );

   function automatic logic [BW-1:0] exp_win(int w);
      logic [BW-1:0] m = BW'(bcount - 1);
      logic [BW-1:0] r;
      case (bmode)
         2'd0:    r = BW'(bcount - 4 + w);
         2'd1:    r = (w < 2) ? BW'(int'(bregs[1]) * 2 + w) : BW'(bcount - 4 + w);
         2'd2:    r = (w == 3 && !blast) ? BW'(bcount - 1) : bregs[w];
         default: r = bregs[3 - w];
      endcase
      return r & m;
   endfunction

   function automatic string mode_tag();
      case (bmode)
         2'd0:    return "R3";
         2'd1:    return "R4";
         2'd2:    return blast ? "R5" : "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(string extra);
      logic lv = (bmode == 2'd2) && !blast && blow;
      for (int w = 0; w < 4; w++) chk({mode_tag(), extra}, win[w], exp_win(w));
      chk({"R7", extra}, low_valid, lv);
      chk({"R7", extra}, low_bank, lv ? (bregs[3] & BW'(bcount - 1)) : 0);
   endtask

   task automatic put(int idx, int data);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IW'(idx); wr_data = BW'(data);
      @(posedge clk);
      if (idx < 4) bregs[idx] = BW'(data);
      else if (idx == 4) begin
         bmode = data[1:0]; blast = data[2]; blow = data[3];
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic put_chk(int idx, int data, string extra);
      put(idx, data);
      @(posedge clk); @(negedge clk);
      check_all(extra);
   endtask

   task automatic set_count(int c);
      @(negedge clk);
      bank_count = 9'(c); bcount = c;
      @(posedge clk); @(negedge clk);
      check_all(" R9 R10 count");
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [BW-1:0] old3;
      void'($urandom(32'd4242));
      for (int i = 0; i < 4; i++) bregs[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int w = 0; w < 4; w++) chk("R1 in reset", win[w], 0);
      chk("R1 in reset", low_valid, 0);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check_all(" R1 after reset");
      put_chk(4, 4'b0011, " R1 regs zero");

      // directed mode walk, count 16
      put_chk(0, 8'h05, " R2");
      put_chk(1, 8'h0B, " R2");
      put_chk(2, 8'h33, " R2");
      put_chk(3, 8'h0E, " R2");
      put_chk(4, 4'b0000, "");
      put_chk(4, 4'b0001, " odd reg1");
      put_chk(4, 4'b0110, "");
      put_chk(4, 4'b0010, "");
      put_chk(4, 4'b1010, " low on");
      put_chk(4, 4'b1110, " low off last sw");
      put_chk(4, 4'b1011, " low off rev");

      // R10 latency
      put(4, 4'b0011);
      @(posedge clk); @(negedge clk);
      old3 = win[3];
      put(0, 8'h09);
      chk("R10 not yet", win[3], old3);
      @(posedge clk); @(negedge clk);
      chk("R10 visible", win[3], 9);

      // R11 unused indices
      for (int k = 5; k < 8; k++) put_chk(k, 8'hFF, " R11 ignored");
      put_chk(4, 4'b1010, " R11 setup");
      put_chk(6, 8'h0F, " R11 ignored low");

      // R9 smallest and largest counts
      put_chk(3, 8'hFF, "");
      set_count(4);
      put_chk(4, 4'b0001, " R9 small");
      put_chk(1, 8'hFF, " R9 small");
      set_count(256);
      put_chk(4, 4'b0000, " R9 big");

      for (int it = 0; it < 600; it++) begin
         if ($urandom % 10 == 0) set_count(4 << ($urandom % 7));
         else if ($urandom % 4 == 0) put_chk(4, $urandom % 16, " rnd");
         else put_chk($urandom % 8, $urandom % 256, " rnd");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule